// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This unit is the event-control part of a small multicycle load/store processor. It holds three control registers for the system coprocessor: a status word, a cause word and a saved-return-address word. The datapath reports exception conditions as plain strobes. These are an ALU overflow on signed add/sub type operations, a system-call instruction and an undecodable instruction. A device raises one interrupt request line. The unit samples all of these at instruction boundaries. When it accepts an event it records the cause code, saves the return PC, pushes the enable nibble of the status word one level deeper (shift left by 4), and steers the next PC to a fixed handler entry address.

The handler inspects the cause word to find out what happened. It reads and writes the three registers with move-from and move-to coprocessor instructions, which reach the unit as a select/data port. It leaves through a return instruction. On return the next PC comes from the saved address and the status word pops back (shift right by 4), which restores the enable state that was in force before entry. An accepted interrupt is answered with a one-cycle acknowledge pulse.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After a synchronous active-low reset, the status register (select 12) reads 32'h0000_0003, and the cause (select 13) and saved-PC (select 14) registers read zero.
- R2: When an event is accepted in a cycle, `pc_redirect` is 1 and `pc_next` is 32'h4 in that same cycle. From the next cycle onwards, saved-PC equals that cycle's `pc_in`, cause equals the 2-bit code zero-extended, and status equals the old status shifted left by 4.
- R3: An overflow is raised only when `arith_op` and `alu_ovf` are both 1. In the cycle an overflow is accepted, `rf_we_out` is 0. In every other cycle, `rf_we_out` follows `rf_we_in`.
- R4: Cause codes are 0 for interrupt, 1 for overflow, 2 for system call and 3 for invalid instruction. When several enabled events coincide, the priority is interrupt, then overflow, then system call, then invalid instruction.
- R5: Events are accepted only in cycles where `instr_done` is 1. `iack` is 1 for exactly the cycle in which an interrupt is accepted, and 0 otherwise.
- R6: Status bit 0 enables interrupts and status bit 1 enables exceptions. A disabled event is ignored: there is no redirect and no register change. A masked interrupt is accepted later, once it is enabled, if `irq` is still held.
- R7: When `instr_done` and `rfe` are both 1, `pc_redirect` is 1 and `pc_next` equals saved-PC in that cycle, and status becomes the old status logically shifted right by 4. No event is accepted in that cycle.
- R8: When `cp0_we` is 1, `cp0_wdata` is written to the register at `cp0_sel` (12, 13 or 14). Any other select writes nothing. An accepted event or a return in the same cycle takes precedence over the write for the registers it updates.
- R9: `cp0_rdata` shows the register at `cp0_sel` in the same cycle, and shows zero for any select other than 12, 13 or 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_done | input | 1 | Current instruction completes this cycle (boundary) |
| pc_in | input | 32 | Address of the current instruction plus 4 |
| arith_op | input | 1 | Current instruction is add, addi or sub |
| alu_ovf | input | 1 | ALU signed overflow flag |
| syscall_op | input | 1 | Current instruction is a system call |
| bad_op | input | 1 | Opcode or function code is undecodable |
| irq | input | 1 | External interrupt request (level) |
| rfe | input | 1 | Current instruction is return-from-exception |
| cp0_we | input | 1 | Move-to-coprocessor write strobe |
| cp0_sel | input | 5 | Coprocessor register select |
| cp0_wdata | input | 32 | Data from the general register |
| rf_we_in | input | 1 | Datapath register-file write request |
| cp0_rdata | output | 32 | Selected coprocessor register, toward register-file write port |
| rf_we_out | output | 1 | Register-file write enable after overflow suppression |
| pc_redirect | output | 1 | Override the next PC |
| pc_next | output | 32 | Next PC when redirecting |
| iack | output | 1 | Interrupt acknowledge pulse |

## Verification
Directed sequences first set up single events of each class against each state of the enables. This separates the priority order from the masking rule, and a pending held interrupt from one that is dropped. Coincident events check that the code recorded is the highest enabled one. Nested entries followed by returns check that the enable nibble is pushed and popped rather than overwritten. A long random phase then mixes boundaries, returns, register writes to valid and invalid selects, and all event strobes. A behavioural model compares every output on every cycle, which catches ordering faults between a write, an entry and a return in the same cycle.

// File: rtl/exc_pkg.sv
// Package: shared constants and types for the exception control unit.
// Assumes a 32-bit machine word and a 5-bit coprocessor register select.
package exc_pkg;
    localparam int XLEN  = 32;
    localparam int SEL_W = 5;

    localparam logic [SEL_W-1:0] SEL_STATUS = 5'd12;
    localparam logic [SEL_W-1:0] SEL_CAUSE  = 5'd13;
    localparam logic [SEL_W-1:0] SEL_EPC    = 5'd14;

    // Event code recorded in the low bits of the cause word; also the priority order.
    typedef enum logic [1:0] {
        EV_INT = 2'd0,
        EV_OVF = 2'd1,
        EV_SYS = 2'd2,
        EV_BAD = 2'd3
    } ev_code_t;

    localparam int NUM_EV = 4;
endpackage

// File: rtl/exc_arbiter.sv
// Module: picks the highest-priority enabled event at an instruction boundary.
// Assumes request bit i corresponds to code i, with lower index meaning higher priority.
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int N = NUM_EV
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         boundary,
    input  logic [N-1:0] req,
    input  logic [N-1:0] enable,
    output logic         take,
    output ev_code_t     code,
    output logic [N-1:0] grant
);
    logic [N-1:0] live;
    logic [N:0]   blocked;

    // Qualify each request by its enable and by the boundary strobe.
    assign live = req & enable & {N{boundary}};

    // Fixed-priority chain: each slot is blocked by any live slot above it.
    assign blocked[0] = 1'b0;
    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign grant[i]     = live[i] & ~blocked[i];
            assign blocked[i+1] = blocked[i] | live[i];
        end
    endgenerate

    assign take = blocked[N];

    // Encode the winning slot into the cause code.
    always_comb begin
        code = EV_INT;
        for (int k = N - 1; k >= 0; k--) begin
            if (grant[k]) code = ev_code_t'(k);
        end
    end

    // R4: at most one event wins per cycle.
    p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R5: nothing wins off an instruction boundary.
    p_boundary_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> boundary);
endmodule

// File: rtl/cp0_regs.sv
// Module: status, cause and saved-PC registers with entry push, return pop and
// software access. Assumes take and pop are never both 1 (the top enforces it).
module cp0_regs
    import exc_pkg::*;
#(
    parameter int W       = XLEN,
    parameter int NIB     = 4,
    parameter logic [W-1:0] RST_STATUS = 32'h0000_0003
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  ev_code_t         code,
    input  logic [W-1:0]     pc_in,
    input  logic             pop,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] sel,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     status,
    output logic [W-1:0]     epc,
    output logic [W-1:0]     rd_data
);
    localparam int CODE_W = $bits(ev_code_t);
    logic [W-1:0] cause;
    logic         wr_status, wr_cause, wr_epc;

    // Decode the software write select.
    assign wr_status = wr_en && (sel == SEL_STATUS);
    assign wr_cause  = wr_en && (sel == SEL_CAUSE);
    assign wr_epc    = wr_en && (sel == SEL_EPC);

    // Status: push on entry, pop on return, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n)         status <= RST_STATUS;
        else if (take)      status <= status << NIB;
        else if (pop)       status <= status >> NIB;
        else if (wr_status) status <= wr_data;
    end

    // Cause: event code on entry, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n)        cause <= '0;
        else if (take)     cause <= {{(W-CODE_W){1'b0}}, code};
        else if (wr_cause) cause <= wr_data;
    end

    // Saved PC: return address on entry, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n)      epc <= '0;
        else if (take)   epc <= pc_in;
        else if (wr_epc) epc <= wr_data;
    end

    // Read mux toward the register-file write port.
    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_data = status;
            SEL_CAUSE:  rd_data = cause;
            SEL_EPC:    rd_data = epc;
            default:    rd_data = '0;
        endcase
    end

    // R2: entry saves the return address.
    p_epc_save_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> epc == $past(pc_in));
    // R2: entry pushes the enable stack.
    p_status_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> status == ($past(status) << NIB));
    // R7: return pops the enable stack.
    p_status_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !take) |=> status == ($past(status) >> NIB));
    // R8: a write to an unmapped select changes nothing.
    p_no_stray_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !take && !pop && sel != SEL_STATUS && sel != SEL_CAUSE && sel != SEL_EPC)
        |=> $stable(status) && $stable(cause) && $stable(epc));
endmodule

// File: rtl/exc_ctrl_unit.sv
// Module: top of the exception and interrupt control unit. Gathers event requests,
// arbitrates them, drives PC redirection, acknowledge and write-back suppression.
// Assumes pc_in already holds the current instruction address plus 4.
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int           W        = XLEN,
    parameter logic [W-1:0] VEC_ADDR = 32'h0000_0004
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_done,
    input  logic [W-1:0]     pc_in,
    input  logic             arith_op,
    input  logic             alu_ovf,
    input  logic             syscall_op,
    input  logic             bad_op,
    input  logic             irq,
    input  logic             rfe,
    input  logic             cp0_we,
    input  logic [SEL_W-1:0] cp0_sel,
    input  logic [W-1:0]     cp0_wdata,
    input  logic             rf_we_in,
    output logic [W-1:0]     cp0_rdata,
    output logic             rf_we_out,
    output logic             pc_redirect,
    output logic [W-1:0]     pc_next,
    output logic             iack
);
    logic [W-1:0]      status, epc;
    logic [NUM_EV-1:0] req, en, grant;
    logic              take, pop, boundary;
    ev_code_t          code;

    // A return closes the instruction and blocks events in that cycle.
    assign pop      = instr_done & rfe;
    assign boundary = instr_done & ~rfe;

    // Request vector in priority order; overflow only from add-type operations.
    assign req = {bad_op, syscall_op, arith_op & alu_ovf, irq};
    // Interrupt uses status bit 0; every exception class uses status bit 1.
    assign en  = {status[1], status[1], status[1], status[0]};

    exc_arbiter #(.N(NUM_EV)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .req      (req),
        .enable   (en),
        .take     (take),
        .code     (code),
        .grant    (grant)
    );

    cp0_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .code    (code),
        .pc_in   (pc_in),
        .pop     (pop),
        .wr_en   (cp0_we),
        .sel     (cp0_sel),
        .wr_data (cp0_wdata),
        .status  (status),
        .epc     (epc),
        .rd_data (cp0_rdata)
    );

    // PC steering: handler entry wins; otherwise return address on a return.
    assign pc_redirect = take | pop;
    assign pc_next     = take ? VEC_ADDR : epc;

    // Acknowledge in the cycle the interrupt is accepted.
    assign iack = grant[EV_INT];

    // Drop the write-back of an overflowing result.
    assign rf_we_out = rf_we_in & ~grant[EV_OVF];

    // R3: an accepted overflow never writes the register file.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grant[EV_OVF] |-> !rf_we_out);
    // R5: acknowledge only for an interrupt at a boundary.
    p_iack_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iack |-> (irq && instr_done && pc_redirect));
    // R6: a disabled interrupt alone never redirects.
    p_int_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[0] && !rfe) |-> !iack);
    // R7: a return redirects to the saved address.
    p_rfe_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (pc_redirect && pc_next == epc && !iack));
endmodule

// File: tb/exc_ctrl_unit_tb.sv
module exc_ctrl_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_done = 0, arith_op = 0, alu_ovf = 0, syscall_op = 0, bad_op = 0;
    logic        irq = 0, rfe = 0, cp0_we = 0, rf_we_in = 0;
    logic [31:0] pc_in = 0, cp0_wdata = 0;
    logic [4:0]  cp0_sel = 0;
    logic [31:0] cp0_rdata, pc_next;
    logic        rf_we_out, pc_redirect, iack;

    int vectors = 0;
    int errors  = 0;
    bit done_flag = 0;

    // Reference state.
    bit [31:0] m_st, m_ca, m_epc;

    always #10 clk = ~clk;  // 50 MHz

    exc_ctrl_unit u_dut (
        .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .pc_in(pc_in),
        .arith_op(arith_op), .alu_ovf(alu_ovf), .syscall_op(syscall_op), .bad_op(bad_op),
        .irq(irq), .rfe(rfe), .cp0_we(cp0_we), .cp0_sel(cp0_sel), .cp0_wdata(cp0_wdata),
        .rf_we_in(rf_we_in), .cp0_rdata(cp0_rdata), .rf_we_out(rf_we_out),
        .pc_redirect(pc_redirect), .pc_next(pc_next), .iack(iack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit [31:0] m_read(input bit [4:0] s);
        case (s)
            5'd12:   return m_st;
            5'd13:   return m_ca;
            5'd14:   return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    // Compare every output against the model, then advance the model and the clock.
    task automatic tick();
        bit take, pop, bnd, e_iack, ovf_take;
        bit [1:0] c;
        #2;
        pop = instr_done && rfe;
        bnd = instr_done && !rfe;
        take = 0; c = 0;
        if (bnd) begin
            if (irq && m_st[0])                          begin take = 1; c = 0; end
            else if (arith_op && alu_ovf && m_st[1])     begin take = 1; c = 1; end
            else if (syscall_op && m_st[1])              begin take = 1; c = 2; end
            else if (bad_op && m_st[1])                  begin take = 1; c = 3; end
        end
        e_iack   = take && c == 0;
        ovf_take = take && c == 1;
        chk("R2/R6/R7 redirect", {31'b0, pc_redirect}, {31'b0, take || pop});
        if (take || pop) chk("R2/R7 pc_next", pc_next, take ? 32'h4 : m_epc);
        chk("R5 iack", {31'b0, iack}, {31'b0, e_iack});
        chk("R3 rf_we_out", {31'b0, rf_we_out}, {31'b0, rf_we_in && !ovf_take});
        chk("R9 cp0_rdata", cp0_rdata, m_read(cp0_sel));
        @(posedge clk);
        if (take) begin
            m_st = m_st << 4; m_ca = {30'b0, c}; m_epc = pc_in;
        end else begin
            if (pop) m_st = m_st >> 4;
            else if (cp0_we && cp0_sel == 12) m_st = cp0_wdata;
            if (cp0_we && cp0_sel == 13) m_ca = cp0_wdata;
            if (cp0_we && cp0_sel == 14) m_epc = cp0_wdata;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        instr_done = 0; arith_op = 0; alu_ovf = 0; syscall_op = 0; bad_op = 0;
        irq = 0; rfe = 0; cp0_we = 0; rf_we_in = 0; cp0_sel = 0;
    endtask

    task automatic rd(input bit [4:0] s, input bit [31:0] exp, input string tag);
        idle(); cp0_sel = s; #2;
        chk(tag, cp0_rdata, exp);
        tick();
    endtask

    task automatic wr(input bit [4:0] s, input bit [31:0] d);
        idle(); cp0_we = 1; cp0_sel = s; cp0_wdata = d; tick();
    endtask

    initial begin
        #4_000_000;
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        m_st = 32'h3; m_ca = 0; m_epc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(12, 32'h3, "R1 status reset");
        rd(13, 32'h0, "R1 cause reset");
        rd(14, 32'h0, "R1 epc reset");

        // R3: overflow flag without add-type op is not an event; write-back kept
        idle(); instr_done = 1; alu_ovf = 1; rf_we_in = 1; pc_in = 32'h100; tick();
        rd(13, 32'h0, "R3 no overflow without arith_op");
        // R3/R2: accepted overflow, write-back suppressed
        idle(); instr_done = 1; arith_op = 1; alu_ovf = 1; rf_we_in = 1; pc_in = 32'h204; tick();
        rd(13, 32'h1, "R2 cause overflow");
        rd(14, 32'h204, "R2 epc saved");
        rd(12, 32'h30, "R2 status pushed");
        // R6: exceptions and interrupts now masked
        idle(); instr_done = 1; syscall_op = 1; bad_op = 1; irq = 1; pc_in = 32'h300; tick();
        rd(14, 32'h204, "R6 masked exception ignored");
        // R7: return pops status
        idle(); instr_done = 1; rfe = 1; irq = 1; tick();
        rd(12, 32'h3, "R7 status popped");
        // R5: held interrupt off boundary is not accepted; at boundary it is
        idle(); irq = 1; tick();
        idle(); irq = 1; instr_done = 1; syscall_op = 1; pc_in = 32'h404; tick();
        rd(13, 32'h0, "R4 interrupt beats syscall");
        idle(); instr_done = 1; rfe = 1; tick();
        // R4: syscall beats invalid
        idle(); instr_done = 1; syscall_op = 1; bad_op = 1; pc_in = 32'h504; tick();
        rd(13, 32'h2, "R4 syscall beats invalid");
        idle(); instr_done = 1; rfe = 1; tick();
        idle(); instr_done = 1; bad_op = 1; pc_in = 32'h604; tick();
        rd(13, 32'h3, "R4 invalid code");
        idle(); instr_done = 1; rfe = 1; tick();
        // R6: only interrupts masked; pending irq taken after enable
        wr(12, 32'h2);
        idle(); instr_done = 1; irq = 1; pc_in = 32'h704; tick();
        rd(12, 32'h2, "R6 masked interrupt pending");
        wr(12, 32'h3);
        idle(); instr_done = 1; irq = 1; pc_in = 32'h804; tick();
        rd(14, 32'h804, "R6 pending interrupt taken");
        idle(); instr_done = 1; rfe = 1; tick();
        // R8: unmapped select ignored; entry wins over same-cycle write
        wr(7, 32'hFFFF_FFFF);
        rd(7, 32'h0, "R9 unmapped reads zero");
        rd(12, 32'h3, "R8 unmapped write ignored");
        idle(); instr_done = 1; syscall_op = 1; cp0_we = 1; cp0_sel = 14; cp0_wdata = 32'hDEAD_BEEF;
        pc_in = 32'h904; tick();
        rd(14, 32'h904, "R8 entry beats write");
        wr(14, 32'h1234_5678);
        rd(14, 32'h1234_5678, "R8 epc write");
        idle(); instr_done = 1; rfe = 1; tick();
        // Nested entry then two returns
        wr(12, 32'h3);
        idle(); instr_done = 1; irq = 1; pc_in = 32'hA04; tick();
        wr(12, 32'h33);
        idle(); instr_done = 1; bad_op = 1; pc_in = 32'hB04; tick();
        rd(12, 32'h330, "R2 nested push");
        idle(); instr_done = 1; rfe = 1; tick();
        idle(); instr_done = 1; rfe = 1; tick();
        rd(12, 32'h3, "R7 nested pop");

        // Random phase: model compared on every cycle.
        for (int i = 0; i < 3000; i++) begin
            idle();
            instr_done = ($urandom % 4) != 0;
            arith_op   = $urandom % 2;
            alu_ovf    = $urandom % 2;
            syscall_op = ($urandom % 6) == 0;
            bad_op     = ($urandom % 8) == 0;
            irq        = ($urandom % 5) == 0;
            rfe        = ($urandom % 5) == 0;
            rf_we_in   = $urandom % 2;
            pc_in      = $urandom & 32'hFFFF_FFFC;
            cp0_sel    = 5'd11 + 5'($urandom % 5);
            cp0_we     = ($urandom % 6) == 0;
            cp0_wdata  = (($urandom % 3) == 0) ? $urandom : 32'h3;
            tick();
        end

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule